// File: doc/BRIEF.md
# APB Transfer Protocol Monitor

A passive observer for one APB segment. It watches one select line per completer plus the enable, direction, address, write data, byte strobes, protection attributes and the completer's ready and error responses. All inputs are sampled on the rising clock edge. The monitor follows the transfer phases (idle, setup, access) and compares each cycle with the one before it. It flags any breach of the phase ordering or of request stability while the transfer waits. It drives nothing on the bus.

Each rule has its own flag bit. A flag stays set until the active-low reset. A one-cycle pulse follows every cycle in which any rule fired. Three free-running counters tally completed reads, completed writes and completions that carried an error response. The monitor is meant to sit next to a bridge or a peripheral during integration and in long-running system tests.

Top module: `apb_protocol_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `viol_flags`, `viol_pulse`, `rd_count`, `wr_count` and `err_count` all read zero.
- R2: A cycle with more than one bit of `sel` high sets `viol_flags[0]`.
- R3: A cycle with a select and `enable` high sets `viol_flags[1]` unless the previous cycle was a setup cycle or a stalled access cycle to the same single completer.
- R4: A setup cycle (one select high, `enable` low) that is not followed by an access cycle to the same completer sets `viol_flags[2]`.
- R5: In an access cycle that continues a setup or stall to the same completer, a change from the previous cycle in `addr`, `write` or `prot` sets `viol_flags[3]`. For writes only, a change in `wdata` or `strb` also sets it. A change of `wdata` during a read sets no flag.
- R6: If `enable` is high in the cycle right after a completion (select, `enable` and `ready` all high), `viol_flags[4]` is set.
- R7: A stalled access cycle (`ready` low) that is not followed by an access cycle to the same completer sets `viol_flags[5]`.
- R8: Flags are sticky until reset. `viol_pulse` is high for exactly the cycle after each cycle in which at least one rule fired.
- R9: Each completion with a single select increments `wr_count` if `write` is high and `rd_count` otherwise. The update is visible one cycle later. Wait-state cycles change neither counter.
- R10: `err_count` increments only when `slverr` is high in a completion cycle. `slverr` in any other cycle is ignored.
- R11: Legal traffic on every completer raises no flag. This covers reads and writes, zero to several wait states, and transfers that follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; clears all state |
| sel | input | N_SEL | One select per completer |
| enable | input | 1 | Access-phase indicator |
| write | input | 1 | Direction, 1 = write |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| strb | input | DATA_W/8 | Write byte-lane enables |
| prot | input | 3 | Protection attributes |
| ready | input | 1 | Completer ready; low stalls the access phase |
| slverr | input | 1 | Completer error response |
| viol_flags | output | 6 | Sticky per-rule violation flags |
| viol_pulse | output | 1 | One-cycle pulse after a cycle with a violation |
| rd_count | output | CNT_W | Completed reads |
| wr_count | output | CNT_W | Completed writes |
| err_count | output | CNT_W | Completions with error response |

## Verification
The assertions assume that the inputs settle between edges and do not change in the sampling window. They assume that `rst_n` is low long enough for one edge to clear the history registers. They also assume that counters never wrap within a test. The bench meets these assumptions: it drives every input one time unit after the rising edge, holds reset for three edges, and keeps each run to a few dozen completions. The legal sweep walks every completer, both directions, zero to two wait states and both error responses in back-to-back order. Inside the stalls it deliberately toggles `slverr` and, during reads, `wdata`, so that the ignored inputs are exercised.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
   localparam int NUM_RULES          = 6;
   localparam int RULE_MULTI_SEL     = 0;
   localparam int RULE_ORPHAN_ACCESS = 1;
   localparam int RULE_SETUP_BREAK   = 2;
   localparam int RULE_REQ_UNSTABLE  = 3;
   localparam int RULE_ENABLE_HELD   = 4;
   localparam int RULE_STALL_BREAK   = 5;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } phase_e;
endpackage

// File: rtl/apb_mon_tracker.sv
module apb_mon_tracker
   import apb_mon_pkg::*;
#(
   parameter int N_SEL  = 4,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SEL-1:0]  sel,
   input  logic              enable,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] strb,
   input  logic [2:0]        prot,
   input  logic              ready,
   output phase_e            cur_phase,
   output logic              cur_single,
   output phase_e            prev_phase,
   output logic              prev_ready,
   output logic [N_SEL-1:0]  prev_sel,
   output logic              prev_write,
   output logic [ADDR_W-1:0] prev_addr,
   output logic [DATA_W-1:0] prev_wdata,
   output logic [STRB_W-1:0] prev_strb,
   output logic [2:0]        prev_prot
);
   logic any_sel;

   always_comb begin
      any_sel    = |sel;
      cur_single = any_sel && ((sel & (sel - 1'b1)) == '0);
      if (!cur_single)  cur_phase = PH_IDLE;
      else if (enable)  cur_phase = PH_ACCESS;
      else              cur_phase = PH_SETUP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_phase <= PH_IDLE;
         prev_ready <= 1'b0;
         prev_sel   <= '0;
         prev_write <= 1'b0;
         prev_addr  <= '0;
         prev_wdata <= '0;
         prev_strb  <= '0;
         prev_prot  <= '0;
      end else begin
         prev_phase <= cur_phase;
         prev_ready <= ready;
         prev_sel   <= sel;
         prev_write <= write;
         prev_addr  <= addr;
         prev_wdata <= wdata;
         prev_strb  <= strb;
         prev_prot  <= prot;
      end
   end
endmodule

// File: rtl/apb_mon_rules.sv
module apb_mon_rules
   import apb_mon_pkg::*;
#(
   parameter int N_SEL      = 4,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter bit CHECK_STRB = 1'b1,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic [N_SEL-1:0]     sel,
   input  logic                 enable,
   input  logic                 write,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [STRB_W-1:0]    strb,
   input  logic [2:0]           prot,
   input  phase_e               prev_phase,
   input  logic                 prev_ready,
   input  logic [N_SEL-1:0]     prev_sel,
   input  logic                 prev_write,
   input  logic [ADDR_W-1:0]    prev_addr,
   input  logic [DATA_W-1:0]    prev_wdata,
   input  logic [STRB_W-1:0]    prev_strb,
   input  logic [2:0]           prev_prot,
   output logic [NUM_RULES-1:0] hits
);
   logic p_setup, p_stall, p_done, acc_now, same_sel, cont;
   logic ctrl_diff, data_diff, strb_diff;

   generate
      if (CHECK_STRB) begin : g_strb_chk
         assign strb_diff = (strb != prev_strb);
      end else begin : g_strb_skip
         assign strb_diff = 1'b0;
      end
   endgenerate

   always_comb begin
      p_setup   = (prev_phase == PH_SETUP);
      p_stall   = (prev_phase == PH_ACCESS) && !prev_ready;
      p_done    = (prev_phase == PH_ACCESS) && prev_ready;
      acc_now   = (|sel) && enable;
      same_sel  = (sel == prev_sel);
      cont      = acc_now && same_sel && (p_setup || p_stall);
      ctrl_diff = (addr != prev_addr) || (write != prev_write) || (prot != prev_prot);
      data_diff = write && ((wdata != prev_wdata) || strb_diff);

      hits                     = '0;
      hits[RULE_MULTI_SEL]     = (sel & (sel - 1'b1)) != '0;
      hits[RULE_ORPHAN_ACCESS] = acc_now && !cont;
      hits[RULE_SETUP_BREAK]   = p_setup && !(acc_now && same_sel);
      hits[RULE_REQ_UNSTABLE]  = cont && (ctrl_diff || data_diff);
      hits[RULE_ENABLE_HELD]   = p_done && enable;
      hits[RULE_STALL_BREAK]   = p_stall && !(acc_now && same_sel);
   end
endmodule

// File: rtl/apb_mon_counter.sv
module apb_mon_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/apb_protocol_monitor.sv
module apb_protocol_monitor
   import apb_mon_pkg::*;
#(
   parameter int N_SEL      = 4,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter bit CHECK_STRB = 1'b1,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SEL-1:0]     sel,
   input  logic                 enable,
   input  logic                 write,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [STRB_W-1:0]    strb,
   input  logic [2:0]           prot,
   input  logic                 ready,
   input  logic                 slverr,
   output logic [NUM_RULES-1:0] viol_flags,
   output logic                 viol_pulse,
   output logic [CNT_W-1:0]     rd_count,
   output logic [CNT_W-1:0]     wr_count,
   output logic [CNT_W-1:0]     err_count
);
   generate
      if (N_SEL < 1) begin : g_bad_nsel
         $error("N_SEL must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 8, 16 or 32");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   phase_e              cur_phase, prev_phase;
   logic                cur_single, prev_ready, prev_write;
   logic [N_SEL-1:0]    prev_sel;
   logic [ADDR_W-1:0]   prev_addr;
   logic [DATA_W-1:0]   prev_wdata;
   logic [STRB_W-1:0]   prev_strb;
   logic [2:0]          prev_prot;
   logic [NUM_RULES-1:0] hits;
   logic                done_now;

   apb_mon_tracker #(.N_SEL(N_SEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
      .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
      .addr(addr), .wdata(wdata), .strb(strb), .prot(prot), .ready(ready),
      .cur_phase(cur_phase), .cur_single(cur_single),
      .prev_phase(prev_phase), .prev_ready(prev_ready), .prev_sel(prev_sel),
      .prev_write(prev_write), .prev_addr(prev_addr), .prev_wdata(prev_wdata),
      .prev_strb(prev_strb), .prev_prot(prev_prot)
   );

   apb_mon_rules #(.N_SEL(N_SEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .CHECK_STRB(CHECK_STRB)) u_rules (
      .sel(sel), .enable(enable), .write(write), .addr(addr), .wdata(wdata),
      .strb(strb), .prot(prot), .prev_phase(prev_phase), .prev_ready(prev_ready),
      .prev_sel(prev_sel), .prev_write(prev_write), .prev_addr(prev_addr),
      .prev_wdata(prev_wdata), .prev_strb(prev_strb), .prev_prot(prev_prot),
      .hits(hits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_flags <= '0;
         viol_pulse <= 1'b0;
      end else begin
         viol_flags <= viol_flags | hits;
         viol_pulse <= |hits;
      end
   end

   assign done_now = (cur_phase == PH_ACCESS) && cur_single && ready;

   logic [2:0] inc_vec;
   assign inc_vec = {done_now && slverr, done_now && write, done_now && !write};
   logic [CNT_W-1:0] cnt_bus [3];

   generate
      for (genvar k = 0; k < 3; k++) begin : g_cnt
         apb_mon_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc_vec[k]), .count(cnt_bus[k])
         );
      end
   endgenerate

   assign rd_count  = cnt_bus[0];
   assign wr_count  = cnt_bus[1];
   assign err_count = cnt_bus[2];
endmodule

// File: rtl/apb_mon_checker.sv
module apb_mon_checker
   import apb_mon_pkg::*;
#(
   parameter int N_SEL = 4,
   parameter int CNT_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_SEL-1:0]     sel,
   input logic                 enable,
   input logic                 write,
   input logic                 ready,
   input logic                 slverr,
   input logic [NUM_RULES-1:0] viol_flags,
   input logic                 viol_pulse,
   input logic [CNT_W-1:0]     rd_count,
   input logic [CNT_W-1:0]     wr_count,
   input logic [CNT_W-1:0]     err_count
);
   localparam logic [CNT_W-1:0] ONE = 1;

   assert_multi_sel_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sel) > 1) |=> (viol_flags[RULE_MULTI_SEL] && viol_pulse));

   assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flags != '0) |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

   assert_pulse_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (viol_flags != '0));

   assert_read_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(sel) && enable && ready && !write) |=> (rd_count == $past(rd_count) + ONE));

   assert_write_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(sel) && enable && ready && write) |=> (wr_count == $past(wr_count) + ONE));

   assert_err_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(enable && ready) || sel == '0) |=> $stable(err_count));

   assert_err_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(sel) && enable && ready && slverr) |=> (err_count == $past(err_count) + ONE));
endmodule

bind apb_protocol_monitor apb_mon_checker #(.N_SEL(N_SEL), .CNT_W(CNT_W)) u_mon_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
   .ready(ready), .slverr(slverr), .viol_flags(viol_flags), .viol_pulse(viol_pulse),
   .rd_count(rd_count), .wr_count(wr_count), .err_count(err_count)
);

// File: tb/test_apb_protocol_monitor.sv
`timescale 1ns/1ps
module test_apb_protocol_monitor;
   localparam int N_SEL = 4, ADDR_W = 12, DATA_W = 32, CNT_W = 16, STRB_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N_SEL-1:0] sel = '0;
   logic enable = 0, write = 0, ready = 0, slverr = 0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [STRB_W-1:0] strb = '0;
   logic [2:0] prot = '0;
   logic [5:0] viol_flags;
   logic viol_pulse;
   logic [CNT_W-1:0] rd_count, wr_count, err_count;

   int checks = 0, errors = 0;
   int exp_rd = 0, exp_wr = 0, exp_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   apb_protocol_monitor #(.N_SEL(N_SEL), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                          .CNT_W(CNT_W)) i_apb_protocol_monitor (
      .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
      .addr(addr), .wdata(wdata), .strb(strb), .prot(prot), .ready(ready),
      .slverr(slverr), .viol_flags(viol_flags), .viol_pulse(viol_pulse),
      .rd_count(rd_count), .wr_count(wr_count), .err_count(err_count)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic go_idle();
      sel = '0; enable = 0; ready = 0; slverr = 0; write = 0;
   endtask

   task automatic do_reset();
      go_idle();
      rst_n = 0;
      repeat (3) cyc();
      rst_n = 1;
      exp_rd = 0; exp_wr = 0; exp_err = 0;
   endtask

   // One legal transfer; leaves bus in completion state (no trailing idle).
   task automatic xfer(input int idx, input bit wr, input int waits, input bit err);
      sel = 4'b1 << idx; enable = 0; write = wr; ready = 0; slverr = 0;
      addr = 12'(idx * 256 + waits * 16 + 4);
      wdata = 32'h0101_0101 * (idx + 1) ^ {31'd0, wr};
      strb = wr ? 4'hF : 4'h0;
      prot = 3'(idx);
      cyc();
      enable = 1;
      for (int w = 0; w < waits; w++) begin
         slverr = 1;                 // ignored outside completion (R10)
         if (!wr) wdata = ~wdata;    // read: wdata change ignored (R5)
         cyc();
      end
      ready = 1; slverr = err;
      cyc();
      if (wr) exp_wr++; else exp_rd++;
      if (err) exp_err++;
   endtask

   initial begin
      #(5.0 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      go_idle();
      rst_n = 0;
      cyc();
      chk("R1 flags in reset", 32'(viol_flags), 0);
      chk("R1 counts in reset", 32'(rd_count + wr_count + err_count), 0);
      repeat (2) cyc();
      rst_n = 1;
      cyc();
      chk("R1 flags after reset", 32'(viol_flags), 0);
      chk("R1 pulse after reset", 32'(viol_pulse), 0);

      // R11/R9/R10 sweep: every completer, direction, wait count, error
      for (int i = 0; i < N_SEL; i++)
         for (int d = 0; d < 2; d++)
            for (int w = 0; w < 3; w++)
               for (int e = 0; e < 2; e++) begin
                  xfer(i, d[0], w, e[0]);
                  chk("R9 rd_count", 32'(rd_count), 32'(exp_rd));
                  chk("R9 wr_count", 32'(wr_count), 32'(exp_wr));
                  chk("R10 err_count", 32'(err_count), 32'(exp_err));
                  if (w == 1) begin
                     go_idle();
                     cyc();
                  end
               end
      go_idle();
      cyc();
      chk("R11 no flags on legal traffic", 32'(viol_flags), 0);
      chk("R11 no pulse on legal traffic", 32'(viol_pulse), 0);

      // R9: wait states do not count
      do_reset();
      sel = 4'b0100; write = 0; addr = 12'h20; cyc();
      enable = 1; cyc(); cyc();
      chk("R9 stall does not count", 32'(rd_count), 0);
      ready = 1; cyc();
      chk("R9 completion counts", 32'(rd_count), 1);
      go_idle(); cyc();

      // R2: multi-select
      do_reset();
      sel = 4'b0011; cyc();
      chk("R2 multi-select flag", 32'(viol_flags), 32'h01);
      chk("R8 pulse after violation", 32'(viol_pulse), 1);
      go_idle(); cyc();
      chk("R8 pulse lasts one cycle", 32'(viol_pulse), 0);
      chk("R8 flag sticky", 32'(viol_flags), 32'h01);

      // R3: access without setup
      do_reset();
      sel = 4'b0001; enable = 1; ready = 1; cyc();
      chk("R3 orphan access", 32'(viol_flags), 32'h02);
      go_idle(); cyc();

      // R4: setup then idle
      do_reset();
      sel = 4'b1000; addr = 12'h44; cyc();
      go_idle(); cyc();
      chk("R4 setup not followed", 32'(viol_flags), 32'h04);

      // R4: setup then access to another completer
      do_reset();
      sel = 4'b0001; cyc();
      sel = 4'b0010; enable = 1; ready = 1; cyc();
      chk("R4 access switches completer", 32'(viol_flags), 32'h06);
      go_idle(); cyc();

      // R5: strobe change during stall of a write
      do_reset();
      sel = 4'b0010; write = 1; addr = 12'h100; wdata = 32'hA5A5_0000; strb = 4'hF; prot = 0;
      cyc();
      enable = 1; cyc();
      strb = 4'h3; cyc();
      chk("R5 strb change in stall", 32'(viol_flags), 32'h08);
      ready = 1; cyc();
      go_idle(); cyc();

      // R5: prot change at access of a read
      do_reset();
      sel = 4'b0001; write = 0; addr = 12'h10; prot = 3'b010; cyc();
      enable = 1; ready = 1; prot = 3'b000; cyc();
      chk("R5 prot change", 32'(viol_flags), 32'h08);
      go_idle(); cyc();

      // R5: address change on write with no wait
      do_reset();
      sel = 4'b0100; write = 1; addr = 12'h30; wdata = 32'h1; strb = 4'hF; prot = 0; cyc();
      enable = 1; ready = 1; addr = 12'h34; cyc();
      chk("R5 addr change", 32'(viol_flags), 32'h08);
      go_idle(); cyc();

      // R6: enable held high after completion
      do_reset();
      xfer(2, 1'b0, 0, 1'b0);
      cyc();   // bus unchanged: enable still high, next cycle
      chk("R6 enable held", 32'(viol_flags), 32'h12);
      go_idle(); cyc();

      // R7: select dropped in stall
      do_reset();
      sel = 4'b0001; write = 1; addr = 12'h8; cyc();
      enable = 1; cyc();
      go_idle(); cyc();
      chk("R7 stall abandoned", 32'(viol_flags), 32'h20);
      chk("R9 abandoned not counted", 32'(wr_count), 0);

      // R10: slverr outside completion ignored
      do_reset();
      sel = 4'b0010; slverr = 1; cyc();
      enable = 1; cyc();
      ready = 1; slverr = 0; cyc();
      chk("R10 slverr ignored outside completion", 32'(err_count), 0);
      go_idle(); slverr = 1; cyc();
      chk("R10 slverr ignored in idle", 32'(err_count), 0);
      go_idle(); cyc();

      // R1: reset clears accumulated state
      sel = 4'b1100; cyc();
      do_reset();
      chk("R1 flags cleared by reset", 32'(viol_flags), 0);
      chk("R1 counts cleared by reset", 32'(rd_count + wr_count + err_count), 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule